// File: doc/BRIEF.md
# Operand Bypass and Writeback Source Selection

This block sits beside the register file of a five-stage in-order integer pipeline. During decode it takes the two source register numbers and the values the register file returns for them. It replaces each value with the newest in-flight result aimed at that register, so a dependent instruction can issue right after its producer. Results can come from three places: the ALU output of the instruction now in execute, the result of the instruction now in memory, and the final write data of the instruction now in writeback.

The block holds the control and data registers between decode and execute, between execute and memory, and between memory and writeback. In the writeback stage it picks the register write value from one of four sources and drives the register file write port.

Three signals from outside control these registers. A global stall freezes them and blocks writes. An exception empties the decode/execute register. When a load in execute feeds the instruction in decode, the block raises a one-cycle load-use request and sends a bubble into execute. The ALU, memory and CSR unit are outside the block; their results come back on input ports.

Top module: `opfwd_bypass`

## Requirements
- R1: While reset is held, every pipeline register is cleared. In the first cycle after reset the write enable, the load-use request and both execute operands are zero.
- R2: A decode operand takes the newest matching producer. The execute stage wins over the memory stage, the memory stage wins over the writeback stage, and the writeback stage wins over the register file data. As a result, a value written 1, 2 or 3 instructions earlier is seen at once, and from 4 instructions back the register file value is used.
- R3: A producer matches only when its write enable is set and its destination equals the source register number. A producer with write enable clear is never forwarded.
- R4: Source register 0 always gives the operand value zero, whatever the register file returns and whatever any producer targets.
- R5: The execute-stage forward value is the ALU result input. The memory-stage forward value is that instruction's selected result, so load data that arrives in memory can be forwarded. The writeback-stage forward value is the register write data.
- R6: The 2-bit result-source code selects the write value: 0 is the ALU result, 1 is the load data, 2 is the instruction address plus 4 (wrapping at 32 bits), and 3 is the CSR read value. Code 1 marks the instruction as a load.
- R7: The register file write enable is high only when the writeback-stage write enable is set, stall is low and the destination is not register 0. The write address is the writeback destination and the write data is the selected value.
- R8: The load-use request is high when the execute stage holds a load with write enable set, a nonzero destination, and a destination equal to either decode source. The next edge then loads a bubble into execute while the memory and writeback stages advance, so the request lasts one cycle.
- R9: While stall is high, the three pipeline registers hold their contents and the write enable is low. Once stall drops, operation resumes with no result lost.
- R10: An exception at a clock edge clears the decode/execute register. The instruction in decode at that edge is dropped, never writes, and both execute operands read zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global pipeline freeze |
| expt | input | 1 | Exception, empties the decode/execute register |
| id_rs1 | input | 5 | First source register number in decode |
| id_rs2 | input | 5 | Second source register number in decode |
| id_rf_rs1_val | input | 32 | Register file read data for id_rs1 |
| id_rf_rs2_val | input | 32 | Register file read data for id_rs2 |
| id_rd | input | 5 | Destination register of the decoded instruction |
| id_wen | input | 1 | Decoded instruction writes a register |
| id_wb_src | input | 2 | Result source code of the decoded instruction |
| id_pc | input | 32 | Address of the decoded instruction |
| ex_alu_res | input | 32 | ALU result for the instruction in execute |
| mem_load_val | input | 32 | Load data for the instruction in memory |
| mem_csr_val | input | 32 | CSR read value for the instruction in memory |
| opnd_rs1 | output | 32 | Forwarded first operand in decode |
| opnd_rs2 | output | 32 | Forwarded second operand in decode |
| ex_opnd_a | output | 32 | First operand held in the decode/execute register |
| ex_opnd_b | output | 32 | Second operand held in the decode/execute register |
| hazard_ld_use | output | 1 | Load-use request |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | 32 | Register file write data |

## Verification
Chains of dependent ALU instructions are issued back to back. Separately, a reader is placed 1, 2, 3 and 4 instructions after its producer, which separates the execute, memory, writeback and register file paths. Three writes to one register in a row, followed by a read, show that the nearest producer wins. A disabled producer and writes to register 0 show that a forward needs a real match. A register file model returns a junk value for register 0, so a forced zero can be told apart from a stale value. A load followed by a dependent, an independent and a distance-2 reader separates the load-use bubble from normal forwarding. Stall and exception runs confirm the held and the emptied pipeline states.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int XLEN  = 32;
    localparam int RAW   = 5;
    localparam int NPROD = 3;
    localparam int NRD   = 2;
    localparam logic [XLEN-1:0] LINK_STEP = XLEN'(4);

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_LOAD = 2'd1,
        WB_LINK = 2'd2,
        WB_CSR  = 2'd3
    } wb_src_e;

    typedef struct packed {
        logic            wen;
        logic [RAW-1:0]  rd;
        wb_src_e         src;
        logic [XLEN-1:0] pc;
    } stage_ctl_t;

    typedef struct packed {
        logic            hit_en;
        logic [RAW-1:0]  rd;
        logic [XLEN-1:0] val;
    } fwd_src_t;

    function automatic logic [XLEN-1:0] pick_wb(
        input wb_src_e         src,
        input logic [XLEN-1:0] alu,
        input logic [XLEN-1:0] ld,
        input logic [XLEN-1:0] pc,
        input logic [XLEN-1:0] csr
    );
        logic [XLEN-1:0] r;
        case (src)
            WB_LOAD: r = ld;
            WB_LINK: r = pc + LINK_STEP;
            WB_CSR:  r = csr;
            default: r = alu;
        endcase
        return r;
    endfunction

    function automatic logic addr_hits(input fwd_src_t p, input logic [RAW-1:0] a);
        return p.hit_en && (p.rd == a) && (a != '0);
    endfunction

endpackage

// File: rtl/opfwd_operand_mux.sv
module opfwd_operand_mux
    import opfwd_pkg::*;
#(
    parameter int NSRC = NPROD
) (
    input  logic [RAW-1:0]  src_addr,
    input  logic [XLEN-1:0] rf_val,
    input  fwd_src_t        prod [NSRC],
    output logic [XLEN-1:0] opnd
);
    // prod[0] is the nearest stage; walking from farthest to nearest lets the
    // nearest hit overwrite the others.
    always_comb begin
        opnd = rf_val;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (addr_hits(prod[i], src_addr)) begin
                opnd = prod[i].val;
            end
        end
        if (src_addr == '0) begin
            opnd = '0;
        end
    end
endmodule

// File: rtl/opfwd_hazard.sv
module opfwd_hazard
    import opfwd_pkg::*;
(
    input  stage_ctl_t     de_ctl,
    input  logic [RAW-1:0] rs1,
    input  logic [RAW-1:0] rs2,
    output logic           ld_use
);
    logic de_is_load;
    logic dst_live;

    always_comb begin
        de_is_load = (de_ctl.src == WB_LOAD);
        dst_live   = de_ctl.wen && (de_ctl.rd != '0);
        ld_use     = de_is_load && dst_live &&
                     ((de_ctl.rd == rs1) || (de_ctl.rd == rs2));
    end
endmodule

// File: rtl/opfwd_stage_regs.sv
module opfwd_stage_regs
    import opfwd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            expt,
    input  logic            ld_bubble,
    input  stage_ctl_t      id_ctl,
    input  logic [XLEN-1:0] id_a,
    input  logic [XLEN-1:0] id_b,
    input  logic [XLEN-1:0] ex_alu,
    input  logic [XLEN-1:0] mem_load,
    input  logic [XLEN-1:0] mem_csr,
    output stage_ctl_t      de_ctl,
    output logic [XLEN-1:0] de_a,
    output logic [XLEN-1:0] de_b,
    output stage_ctl_t      em_ctl,
    output logic [XLEN-1:0] em_alu,
    output stage_ctl_t      mw_ctl,
    output logic [XLEN-1:0] mw_alu,
    output logic [XLEN-1:0] mw_load,
    output logic [XLEN-1:0] mw_csr
);
    // decode -> execute: cleared on reset or exception, bubbled on load-use
    always_ff @(posedge clk) begin
        if (rst || expt) begin
            de_ctl <= '0;
            de_a   <= '0;
            de_b   <= '0;
        end else if (!stall) begin
            if (ld_bubble) begin
                de_ctl <= '0;
                de_a   <= '0;
                de_b   <= '0;
            end else begin
                de_ctl <= id_ctl;
                de_a   <= id_a;
                de_b   <= id_b;
            end
        end
    end

    // execute -> memory
    always_ff @(posedge clk) begin
        if (rst) begin
            em_ctl <= '0;
            em_alu <= '0;
        end else if (!stall) begin
            em_ctl <= de_ctl;
            em_alu <= ex_alu;
        end
    end

    // memory -> writeback
    always_ff @(posedge clk) begin
        if (rst) begin
            mw_ctl  <= '0;
            mw_alu  <= '0;
            mw_load <= '0;
            mw_csr  <= '0;
        end else if (!stall) begin
            mw_ctl  <= em_ctl;
            mw_alu  <= em_alu;
            mw_load <= mem_load;
            mw_csr  <= mem_csr;
        end
    end
endmodule

// File: rtl/opfwd_wb_port.sv
module opfwd_wb_port
    import opfwd_pkg::*;
(
    input  logic            stall,
    input  stage_ctl_t      mw_ctl,
    input  logic [XLEN-1:0] mw_alu,
    input  logic [XLEN-1:0] mw_load,
    input  logic [XLEN-1:0] mw_csr,
    output logic            rf_we,
    output logic [RAW-1:0]  rf_waddr,
    output logic [XLEN-1:0] rf_wdata
);
    always_comb begin
        rf_wdata = pick_wb(mw_ctl.src, mw_alu, mw_load, mw_ctl.pc, mw_csr);
        rf_waddr = mw_ctl.rd;
        rf_we    = mw_ctl.wen && !stall && (mw_ctl.rd != '0);
    end
endmodule

// File: rtl/opfwd_bypass.sv
module opfwd_bypass
    import opfwd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            expt,
    input  logic [RAW-1:0]  id_rs1,
    input  logic [RAW-1:0]  id_rs2,
    input  logic [XLEN-1:0] id_rf_rs1_val,
    input  logic [XLEN-1:0] id_rf_rs2_val,
    input  logic [RAW-1:0]  id_rd,
    input  logic            id_wen,
    input  logic [1:0]      id_wb_src,
    input  logic [XLEN-1:0] id_pc,
    input  logic [XLEN-1:0] ex_alu_res,
    input  logic [XLEN-1:0] mem_load_val,
    input  logic [XLEN-1:0] mem_csr_val,
    output logic [XLEN-1:0] opnd_rs1,
    output logic [XLEN-1:0] opnd_rs2,
    output logic [XLEN-1:0] ex_opnd_a,
    output logic [XLEN-1:0] ex_opnd_b,
    output logic            hazard_ld_use,
    output logic            rf_we,
    output logic [RAW-1:0]  rf_waddr,
    output logic [XLEN-1:0] rf_wdata
);
    localparam int P_EX  = 0;
    localparam int P_MEM = 1;
    localparam int P_WB  = 2;

    stage_ctl_t      id_ctl, de_ctl, em_ctl, mw_ctl;
    logic [XLEN-1:0] em_alu, mw_alu, mw_load, mw_csr;
    fwd_src_t        prod [NPROD];
    logic [RAW-1:0]  rd_addr [NRD];
    logic [XLEN-1:0] rd_rf   [NRD];
    logic [XLEN-1:0] rd_opnd [NRD];

    always_comb begin
        id_ctl.wen = id_wen;
        id_ctl.rd  = id_rd;
        id_ctl.src = wb_src_e'(id_wb_src);
        id_ctl.pc  = id_pc;
    end

    // producers, nearest first
    always_comb begin
        prod[P_EX].hit_en  = de_ctl.wen && (de_ctl.src != WB_LOAD);
        prod[P_EX].rd      = de_ctl.rd;
        prod[P_EX].val     = ex_alu_res;
        prod[P_MEM].hit_en = em_ctl.wen;
        prod[P_MEM].rd     = em_ctl.rd;
        prod[P_MEM].val    = pick_wb(em_ctl.src, em_alu, mem_load_val, em_ctl.pc, mem_csr_val);
        prod[P_WB].hit_en  = mw_ctl.wen;
        prod[P_WB].rd      = mw_ctl.rd;
        prod[P_WB].val     = rf_wdata;
    end

    always_comb begin
        rd_addr[0] = id_rs1;
        rd_addr[1] = id_rs2;
        rd_rf[0]   = id_rf_rs1_val;
        rd_rf[1]   = id_rf_rs2_val;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_port
        opfwd_operand_mux #(.NSRC(NPROD)) i_mux (
            .src_addr (rd_addr[g]),
            .rf_val   (rd_rf[g]),
            .prod     (prod),
            .opnd     (rd_opnd[g])
        );
    end

    assign opnd_rs1 = rd_opnd[0];
    assign opnd_rs2 = rd_opnd[1];

    opfwd_hazard i_hazard (
        .de_ctl (de_ctl),
        .rs1    (id_rs1),
        .rs2    (id_rs2),
        .ld_use (hazard_ld_use)
    );

    opfwd_stage_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .expt      (expt),
        .ld_bubble (hazard_ld_use),
        .id_ctl    (id_ctl),
        .id_a      (opnd_rs1),
        .id_b      (opnd_rs2),
        .ex_alu    (ex_alu_res),
        .mem_load  (mem_load_val),
        .mem_csr   (mem_csr_val),
        .de_ctl    (de_ctl),
        .de_a      (ex_opnd_a),
        .de_b      (ex_opnd_b),
        .em_ctl    (em_ctl),
        .em_alu    (em_alu),
        .mw_ctl    (mw_ctl),
        .mw_alu    (mw_alu),
        .mw_load   (mw_load),
        .mw_csr    (mw_csr)
    );

    opfwd_wb_port i_wb (
        .stall    (stall),
        .mw_ctl   (mw_ctl),
        .mw_alu   (mw_alu),
        .mw_load  (mw_load),
        .mw_csr   (mw_csr),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );
endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk
    import opfwd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic            expt,
    input logic [RAW-1:0]  id_rs1,
    input logic [RAW-1:0]  id_rs2,
    input logic [XLEN-1:0] opnd_rs1,
    input logic [XLEN-1:0] opnd_rs2,
    input logic [XLEN-1:0] ex_opnd_a,
    input logic [XLEN-1:0] ex_opnd_b,
    input logic            hazard_ld_use,
    input logic            rf_we,
    input logic [RAW-1:0]  rf_waddr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rf_we && !hazard_ld_use && ex_opnd_a == '0 && ex_opnd_b == '0));

    // R4
    zero_rs1_chk: assert property (@(posedge clk) disable iff (rst)
        (id_rs1 == '0) |-> (opnd_rs1 == '0));

    // R4
    zero_rs2_chk: assert property (@(posedge clk) disable iff (rst)
        (id_rs2 == '0) |-> (opnd_rs2 == '0));

    // R7
    no_x0_write_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '0));

    // R8
    ld_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (hazard_ld_use && !stall) |=> (!hazard_ld_use && ex_opnd_a == '0 && ex_opnd_b == '0));

    // R9
    stall_write_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> !rf_we);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !expt) |=> ($stable(ex_opnd_a) && $stable(ex_opnd_b) && $stable(rf_waddr)));

    // R10
    expt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        expt |=> (ex_opnd_a == '0 && ex_opnd_b == '0));
endmodule

bind opfwd_bypass opfwd_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .stall         (stall),
    .expt          (expt),
    .id_rs1        (id_rs1),
    .id_rs2        (id_rs2),
    .opnd_rs1      (opnd_rs1),
    .opnd_rs2      (opnd_rs2),
    .ex_opnd_a     (ex_opnd_a),
    .ex_opnd_b     (ex_opnd_b),
    .hazard_ld_use (hazard_ld_use),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr)
);

// File: tb/test_opfwd_bypass.sv
module test_opfwd_bypass;
    import opfwd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] LD_VAL  = 32'h0000_5A17;
    localparam logic [31:0] CSR_VAL = 32'h0000_0C51;
    localparam logic [31:0] X0_JUNK = 32'hBAD0_0BAD;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst = 1'b1, stall = 1'b0, expt = 1'b0;
    logic [4:0]  id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic        id_wen = 1'b0;
    logic [1:0]  id_wb_src = 2'd0;
    logic [31:0] id_pc = '0;
    logic [31:0] id_rf_rs1_val, id_rf_rs2_val, ex_alu_res;
    logic [31:0] opnd_rs1, opnd_rs2, ex_opnd_a, ex_opnd_b, rf_wdata;
    logic        hazard_ld_use, rf_we;
    logic [4:0]  rf_waddr;

    logic [31:0] rf_m [32];
    logic [31:0] gold [32];
    int          total = 0, bad = 0, x0_writes = 0;
    logic [31:0] pc_cnt = 32'h0000_0100;
    logic        prev_ld = 1'b0, prev_wen = 1'b0;
    logic [4:0]  prev_rd = '0;
    bit          done = 1'b0;

    assign id_rf_rs1_val = (id_rs1 == 5'd0) ? X0_JUNK : rf_m[id_rs1];
    assign id_rf_rs2_val = (id_rs2 == 5'd0) ? X0_JUNK : rf_m[id_rs2];
    assign ex_alu_res    = ex_opnd_a + ex_opnd_b;   // ALU model: add

    opfwd_bypass i_opfwd_bypass (
        .clk(clk), .rst(rst), .stall(stall), .expt(expt),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rf_rs1_val(id_rf_rs1_val), .id_rf_rs2_val(id_rf_rs2_val),
        .id_rd(id_rd), .id_wen(id_wen), .id_wb_src(id_wb_src), .id_pc(id_pc),
        .ex_alu_res(ex_alu_res), .mem_load_val(LD_VAL), .mem_csr_val(CSR_VAL),
        .opnd_rs1(opnd_rs1), .opnd_rs2(opnd_rs2),
        .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
        .hazard_ld_use(hazard_ld_use),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // register file model, written only through the write port
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) rf_m[i] <= '0;
        end else if (rf_we) begin
            rf_m[rf_waddr] <= rf_wdata;
            if (rf_waddr == 5'd0) x0_writes++;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic wen, input wb_src_e src);
        id_rd = rd; id_rs1 = rs1; id_rs2 = rs2; id_wen = wen;
        id_wb_src = src; id_pc = pc_cnt;
    endtask

    task automatic issue(input string tag, input logic [4:0] rd, input logic [4:0] rs1,
                         input logic [4:0] rs2, input logic wen, input wb_src_e src);
        logic        exp_lu;
        logic [31:0] a, b, v;
        @(negedge clk);
        stall = 1'b0; expt = 1'b0;
        drive(rd, rs1, rs2, wen, src);
        exp_lu = prev_ld && prev_wen && (prev_rd != 5'd0) && (prev_rd == rs1 || prev_rd == rs2);
        #1;
        chk("R8", "load-use request", {31'd0, hazard_ld_use}, {31'd0, exp_lu});
        if (exp_lu) begin
            @(negedge clk);
            #1;
            chk("R8", "request after bubble", {31'd0, hazard_ld_use}, 32'd0);
        end
        a = gold[rs1];
        b = gold[rs2];
        chk(tag, "operand rs1", opnd_rs1, a);
        chk(tag, "operand rs2", opnd_rs2, b);
        case (src)
            WB_LOAD: v = LD_VAL;
            WB_LINK: v = pc_cnt + 32'd4;
            WB_CSR:  v = CSR_VAL;
            default: v = a + b;
        endcase
        if (wen && rd != 5'd0) gold[rd] = v;
        prev_ld = (src == WB_LOAD); prev_wen = wen; prev_rd = rd;
        pc_cnt += 32'd4;
    endtask

    task automatic nop(input string tag);
        issue(tag, 5'd0, 5'd0, 5'd0, 1'b0, WB_ALU);
    endtask

    task automatic drain_and_compare(input string tag);
        for (int i = 0; i < 4; i++) nop(tag);
        @(negedge clk);
        #1;
        for (int r = 1; r < 32; r++) chk("R7", $sformatf("%s rf x%0d", tag, r), rf_m[r], gold[r]);
        chk("R7", "writes to x0", x0_writes, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(5'd3, 5'd1, 5'd2, 1'b1, WB_LINK);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "write enable", {31'd0, rf_we}, 32'd0);
        chk("R1", "load-use", {31'd0, hazard_ld_use}, 32'd0);
        chk("R1", "ex operand a", ex_opnd_a, 32'd0);
        chk("R1", "ex operand b", ex_opnd_b, 32'd0);
        rst = 1'b0;
        drive(5'd0, 5'd0, 5'd0, 1'b0, WB_ALU);
    endtask

    task automatic t_seed_chain;
        issue("R6", 5'd1, 5'd0, 5'd0, 1'b1, WB_LINK);
        issue("R6", 5'd2, 5'd0, 5'd0, 1'b1, WB_CSR);
        issue("R6", 5'd3, 5'd0, 5'd0, 1'b1, WB_LOAD);
        issue("R6", 5'd4, 5'd0, 5'd0, 1'b1, WB_LINK);
        issue("R2", 5'd5, 5'd1, 5'd2, 1'b1, WB_ALU);
        issue("R5", 5'd6, 5'd5, 5'd5, 1'b1, WB_ALU);
        issue("R5", 5'd7, 5'd6, 5'd5, 1'b1, WB_ALU);
        issue("R5", 5'd8, 5'd3, 5'd4, 1'b1, WB_ALU);
        issue("R2", 5'd9, 5'd7, 5'd8, 1'b1, WB_ALU);
        drain_and_compare("chain");
    endtask

    task automatic t_distance;
        for (int d = 1; d <= 4; d++) begin
            issue("R2", 5'd13, 5'd13, 5'd1, 1'b1, WB_ALU);
            for (int k = 1; k < d; k++) nop("R2");
            issue("R2", 5'd14, 5'd13, 5'd13, 1'b1, WB_ALU);
        end
        drain_and_compare("distance");
    endtask

    task automatic t_priority;
        issue("R6", 5'd9, 5'd0, 5'd0, 1'b1, WB_LINK);
        issue("R6", 5'd9, 5'd0, 5'd0, 1'b1, WB_CSR);
        issue("R2", 5'd9, 5'd1, 5'd2, 1'b1, WB_ALU);
        issue("R2", 5'd16, 5'd9, 5'd9, 1'b1, WB_ALU);
        issue("R6", 5'd15, 5'd0, 5'd0, 1'b1, WB_LINK);
        issue("R5", 5'd15, 5'd5, 5'd1, 1'b1, WB_CSR);
        nop("R2");
        issue("R5", 5'd17, 5'd15, 5'd2, 1'b1, WB_ALU);
        drain_and_compare("priority");
    endtask

    task automatic t_no_enable;
        issue("R3", 5'd6, 5'd1, 5'd1, 1'b0, WB_ALU);
        issue("R3", 5'd18, 5'd6, 5'd0, 1'b1, WB_ALU);
        issue("R3", 5'd7, 5'd2, 5'd2, 1'b0, WB_CSR);
        nop("R3");
        issue("R3", 5'd18, 5'd7, 5'd6, 1'b1, WB_ALU);
        drain_and_compare("no-enable");
    endtask

    task automatic t_x0;
        issue("R4", 5'd0, 5'd1, 5'd2, 1'b1, WB_ALU);
        issue("R4", 5'd19, 5'd0, 5'd0, 1'b1, WB_ALU);
        issue("R4", 5'd0, 5'd0, 5'd0, 1'b1, WB_LINK);
        nop("R4");
        issue("R4", 5'd20, 5'd0, 5'd1, 1'b1, WB_ALU);
        issue("R4", 5'd0, 5'd0, 5'd0, 1'b1, WB_LOAD);
        issue("R4", 5'd21, 5'd0, 5'd0, 1'b1, WB_ALU);
        drain_and_compare("x0");
    endtask

    task automatic t_load_use;
        issue("R8", 5'd10, 5'd0, 5'd0, 1'b1, WB_LOAD);
        issue("R8", 5'd11, 5'd10, 5'd1, 1'b1, WB_ALU);
        issue("R8", 5'd12, 5'd0, 5'd0, 1'b1, WB_LOAD);
        issue("R8", 5'd22, 5'd1, 5'd2, 1'b1, WB_ALU);
        issue("R5", 5'd23, 5'd12, 5'd22, 1'b1, WB_ALU);
        issue("R8", 5'd24, 5'd0, 5'd0, 1'b1, WB_LOAD);
        issue("R8", 5'd25, 5'd2, 5'd24, 1'b1, WB_ALU);
        issue("R8", 5'd26, 5'd0, 5'd0, 1'b0, WB_LOAD);
        issue("R8", 5'd27, 5'd26, 5'd0, 1'b1, WB_ALU);
        drain_and_compare("load-use");
    endtask

    task automatic t_stall;
        logic [31:0] held_a, held_b;
        issue("R9", 5'd28, 5'd1, 5'd2, 1'b1, WB_ALU);
        issue("R9", 5'd29, 5'd28, 5'd1, 1'b1, WB_ALU);
        issue("R9", 5'd30, 5'd29, 5'd28, 1'b1, WB_ALU);
        held_a = '0; held_b = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            stall = 1'b1;
            drive(5'd0, 5'd0, 5'd0, 1'b0, WB_ALU);
            #1;
            chk("R9", "write blocked in stall", {31'd0, rf_we}, 32'd0);
            if (i == 0) begin
                held_a = ex_opnd_a; held_b = ex_opnd_b;
            end else begin
                chk("R9", "ex operand a held", ex_opnd_a, held_a);
                chk("R9", "ex operand b held", ex_opnd_b, held_b);
            end
        end
        issue("R9", 5'd31, 5'd30, 5'd29, 1'b1, WB_ALU);
        issue("R9", 5'd5, 5'd31, 5'd28, 1'b1, WB_ALU);
        drain_and_compare("stall");
    endtask

    task automatic t_expt;
        issue("R10", 5'd8, 5'd1, 5'd2, 1'b1, WB_ALU);
        @(negedge clk);
        expt = 1'b1;
        drive(5'd8, 5'd1, 5'd2, 1'b1, WB_LINK);
        pc_cnt += 32'd4;
        @(negedge clk);
        expt = 1'b0;
        drive(5'd0, 5'd0, 5'd0, 1'b0, WB_ALU);
        #1;
        chk("R10", "ex operand a cleared", ex_opnd_a, 32'd0);
        chk("R10", "ex operand b cleared", ex_opnd_b, 32'd0);
        prev_ld = 1'b0; prev_wen = 1'b0; prev_rd = '0;
        issue("R10", 5'd9, 5'd8, 5'd8, 1'b1, WB_ALU);
        drain_and_compare("exception");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gold[i] = '0;
        t_reset();
        t_seed_chain();
        t_distance();
        t_priority();
        t_no_enable();
        t_x0();
        t_load_use();
        t_stall();
        t_expt();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule